// File: doc/BRIEF.md
# Sticky Active-Low Status Register

This block is a two-byte status register that a host microcontroller reads over a byte-wide read port. Status byte 0 holds seven error and condition flags. Each flag is active low and sticky: it drops to 0 when its event strobe fires. It stays at 0 until the host reads byte 0, even if the event never repeats. The top bit of byte 0 shows the active transfer direction. That bit moves to the configured direction only when the mode switch reports that it has completed.

Status byte 1 is a registered mirror of live settings. Bits 0 to 5 copy six configuration levels: audio mute, coded output enable, input sensitivity select, serial audio output enable, serial audio source select, and clock ratio select. Bits 6 and 7 carry the two channel-status mode bits, inverted and in swapped order.

The host drives a byte select and a read strobe. The selected byte is presented combinationally on the read data port. A strobed read of byte 0 re-arms its flags at the next clock edge.

Top module: `dio_status_reg`

## Requirements
- R1: While reset is asserted, and after it until other stimulus arrives, both bytes read 8'hFF (all flags high, direction 1, mirror all ones).
- R2: A one-cycle pulse on `evt[i]` (i = 0..6) makes bit i of byte 0 read 0 from the next clock edge. Bit 0 is professional mode, bit 1 is loss of lock, bit 2 is validity, bit 3 is parity, bit 4 is biphase violation, bit 5 is user data overrun and bit 6 is channel-status change.
- R3: A flag at 0 stays at 0 on later cycles with no event, until byte 0 is read.
- R4: A strobed read of byte 0 (`rd_sel` = 0, `rd_stb` = 1) returns the current flags. From the next edge, every flag with no event in that cycle reads 1.
- R5: If `evt[i]` fires in the same cycle as a byte 0 read, bit i reads 0 after the edge.
- R6: A strobed read of byte 1 (`rd_sel` = 1) leaves all byte 0 flags unchanged.
- R7: Byte 0 bit 7 (0 = receive, 1 = transmit) takes the value of `dir_cfg` at an edge where `dir_done` is 1. At every other edge it holds its value.
- R8: Byte 1 bits 5:0 equal `cfg_live[5:0]` as sampled at the previous clock edge.
- R9: Byte 1 bit 6 equals the inverse of `cs_b7`, and bit 7 equals the inverse of `cs_b6`. Both are sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 7 | Single-cycle event strobes, one per byte 0 flag |
| dir_cfg | input | 1 | Configured direction, 1 = transmit |
| dir_done | input | 1 | Pulse: direction change has taken effect |
| cfg_live | input | 6 | Live configuration levels mirrored into byte 1 |
| cs_b6 | input | 1 | Channel-status mode bit 6 |
| cs_b7 | input | 1 | Channel-status mode bit 7 |
| rd_stb | input | 1 | Read strobe; a byte 0 read clears its flags |
| rd_sel | input | 1 | Byte select, 0 = byte 0, 1 = byte 1 |
| rd_data | output | 8 | Selected status byte |

## Verification
All state in this block is visible at `rd_data`, so a wrong internal state shows up when the affected byte is next selected. A lost or spuriously cleared flag shows one edge after the event or read that caused it. A direction bit that moves without `dir_done` shows one edge after the `dir_cfg` change. A swapped or uninverted mode bit shows one edge after the channel-status inputs change. The bench peeks at both bytes after every clock edge and compares them with a cycle-level model. This catches each of these faults at the first cycle it can appear.

// File: rtl/dio_status_reg.sv
`timescale 1ns/100ps
module dio_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] evt,
  input  logic       dir_cfg,
  input  logic       dir_done,
  input  logic [5:0] cfg_live,
  input  logic       cs_b6,
  input  logic       cs_b7,
  input  logic       rd_stb,
  input  logic       rd_sel,
  output logic [7:0] rd_data
);
  logic [6:0] flags;
  logic       dir_q;
  logic [7:0] mirror_q;
  logic       rearm;

  assign rearm   = rd_stb & ~rd_sel;
  assign rd_data = rd_sel ? mirror_q : {dir_q, flags};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '1;
      dir_q    <= 1'b1;
      mirror_q <= '1;
    end else begin
      flags    <= (rearm ? 7'h7F : flags) & ~evt;
      mirror_q <= {~cs_b6, ~cs_b7, cfg_live};
      if (dir_done) dir_q <= dir_cfg;
    end
  end
endmodule

module dio_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] evt,
  input logic       dir_cfg,
  input logic       dir_done,
  input logic [5:0] cfg_live,
  input logic       cs_b6,
  input logic       cs_b7,
  input logic       rd_stb,
  input logic       rd_sel,
  input logic [6:0] flags,
  input logic       dir_q,
  input logic [7:0] mirror_q
);
  always @(negedge clk)
    if (rst_n === 1'b0)
      AST_RESET_ONES: assert (flags == 7'h7F && dir_q && mirror_q == 8'hFF); // R1

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == 7'h0)); // R2

  AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && !rd_sel) |=> ((flags & ~$past(flags)) == 7'h0)); // R3

  AST_READ_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_sel && evt == 7'h0) |=> (flags == 7'h7F)); // R4

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_sel && |evt) |=> (flags == ~$past(evt))); // R5

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_done |=> $stable(dir_q)); // R7

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dir_done |=> (dir_q == $past(dir_cfg))); // R7

  AST_MIRROR_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mirror_q[5:0] == $past(cfg_live))); // R8

  AST_MIRROR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (mirror_q[6] != $past(cs_b7) && mirror_q[7] != $past(cs_b6))); // R9
endmodule

bind dio_status_reg dio_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .dir_cfg(dir_cfg), .dir_done(dir_done),
  .cfg_live(cfg_live), .cs_b6(cs_b6), .cs_b7(cs_b7), .rd_stb(rd_stb),
  .rd_sel(rd_sel), .flags(flags), .dir_q(dir_q), .mirror_q(mirror_q)
);

// File: tb/sim_dio_status_reg.sv
`timescale 1ns/100ps
module sim_dio_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic       dir_cfg = 1'b0, dir_done = 1'b0;
  logic [5:0] cfg_live = '0;
  logic       cs_b6 = 1'b0, cs_b7 = 1'b0;
  logic       rd_stb = 1'b0, rd_sel = 1'b0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [6:0] m_flags = 7'h7F;
  logic       m_dir = 1'b1;
  logic [7:0] m_mir = 8'hFF;

  always #2.5 clk = ~clk;

  dio_status_reg u0 (.clk(clk), .rst_n(rst_n), .evt(evt), .dir_cfg(dir_cfg),
    .dir_done(dir_done), .cfg_live(cfg_live), .cs_b6(cs_b6), .cs_b7(cs_b7),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input string req);
    rd_stb = 1'b0;
    rd_sel = 1'b0; #0.5;
    check(rd_data, {m_dir, m_flags}, {req, " byte0"});
    rd_sel = 1'b1; #0.5;
    check(rd_data, m_mir, {req, " byte1"});
    rd_sel = 1'b0;
  endtask

  task automatic cyc(input logic [6:0] e, input logic rd, input logic sel,
                     input logic dc, input logic dd, input logic [5:0] cf,
                     input logic c6, input logic c7, input string req);
    @(negedge clk);
    evt = e; rd_stb = rd; rd_sel = sel; dir_cfg = dc; dir_done = dd;
    cfg_live = cf; cs_b6 = c6; cs_b7 = c7;
    #0.5;
    if (rd) check(rd_data, sel ? m_mir : {m_dir, m_flags}, {req, " read value"});
    @(posedge clk);
    if (rd && !sel) m_flags = 7'h7F & ~e;
    else            m_flags = m_flags & ~e;
    if (dd) m_dir = dc;
    m_mir = {~c6, ~c7, cf};
    #1;
    evt = '0; dir_done = 1'b0;
    peek(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset value on both bytes, inputs busy during reset
    evt = 7'h55; cfg_live = 6'h00; dir_done = 1'b1;
    repeat (3) @(posedge clk);
    #1; rd_sel = 1'b0; #0.5; check(rd_data, 8'hFF, "R1 byte0 in reset");
    rd_sel = 1'b1; #0.5; check(rd_data, 8'hFF, "R1 byte1 in reset");
    @(negedge clk);
    evt = '0; dir_done = 1'b0; cfg_live = 6'h3F; cs_b6 = 1'b0; cs_b7 = 1'b0; rd_sel = 1'b0;
    rst_n = 1'b1;
    #0.5; check(rd_data, 8'hFF, "R1 byte0 after reset");

    // R2, R3, R4: each flag latches, stays, then re-arms on byte 0 read
    for (int i = 0; i < 7; i++) begin
      cyc(7'(1 << i), 0, 0, 1, 0, 6'h3F, 0, 0, "R2");
      cyc(7'h00, 0, 0, 1, 0, 6'h3F, 0, 0, "R3");
      cyc(7'h00, 0, 0, 1, 0, 6'h3F, 0, 0, "R3");
      cyc(7'h00, 1, 0, 1, 0, 6'h3F, 0, 0, "R4");
    end

    // R6: byte 1 read keeps flags
    cyc(7'h7F, 0, 0, 1, 0, 6'h3F, 0, 0, "R2");
    cyc(7'h00, 1, 1, 1, 0, 6'h3F, 0, 0, "R6");
    cyc(7'h00, 1, 1, 1, 0, 6'h3F, 0, 0, "R6");
    cyc(7'h00, 1, 0, 1, 0, 6'h3F, 0, 0, "R4");

    // R5: event in the same cycle as a byte 0 read
    for (int i = 0; i < 7; i++) begin
      cyc(7'h7F, 0, 0, 1, 0, 6'h3F, 0, 0, "R2");
      cyc(7'(1 << i), 1, 0, 1, 0, 6'h3F, 0, 0, "R5");
      cyc(7'h00, 1, 0, 1, 0, 6'h3F, 0, 0, "R4");
    end

    // R7: direction moves only with the completion pulse
    for (int v = 0; v < 4; v++) begin
      cyc(7'h00, 0, 0, v[0], 0, 6'h3F, 0, 0, "R7 hold");
      cyc(7'h00, 0, 0, v[1], 0, 6'h3F, 0, 0, "R7 hold");
      cyc(7'h00, 0, 0, v[1], 1, 6'h3F, 0, 0, "R7 load");
      cyc(7'h00, 0, 0, ~v[1], 0, 6'h3F, 0, 0, "R7 hold");
    end

    // R8, R9: full sweep of mirrored inputs
    for (int v = 0; v < 256; v++)
      cyc(7'h00, 0, 0, 0, 0, v[5:0], v[6], v[7], (v[7:6] != 0) ? "R9" : "R8");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc((r[2:0] == 0) ? r[9:3] : 7'h00, r[10], r[11], r[12], r[13],
          r[19:14], r[20], r[21], "R2");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule